// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen logical general registers of a processor core whose working set depends on the current five-bit operating mode. Logical register numbers are translated into physical storage locations before every access. An exception handler therefore finds private copies of some registers already in place, and the interrupted program's values in those registers stay intact without any save sequence. The fast-interrupt mode gets the largest private set, seven registers. Every other exception mode keeps private copies of only the stack pointer (r13) and the link register (r14).

Two read ports and one write port take logical register numbers and share the mode input. The block also keeps one saved-status word for each of the five exception modes. That word has its own read output and its own write strobe, and both act on the bank of the current mode. All outputs are registered: data for an index presented before a rising edge is valid after that edge. Mode transition control and program-counter arithmetic are left to surrounding logic.

Top module: `banked_regfile`

## Requirements
- R1: Logical registers r0 to r7 address the same storage in every mode, so a value written to one of them in any mode is read back in any other mode.
- R2: In fast-interrupt mode (mode input 10001), r8 to r14 address seven private locations. Writes there leave the user copies of r8 to r14 unchanged, and user-mode writes leave the private copies unchanged.
- R3: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private r13 and r14. In those modes r8 to r12 address the user copies.
- R4: r15 is a single location shared by all modes.
- R5: System mode (11111), user mode (10000) and every mode value not listed in R2 or R3 address the user copies of all sixteen registers.
- R6: Read data and saved-status output are registered and show the result one clock edge after the index and mode are presented. A synchronous active-high reset drives both read outputs, the saved-status output and all five saved-status words to zero.
- R7: If a read port and the write port select the same physical location in the same cycle, the read output shows the data being written.
- R8: Each of the five exception modes in R2 and R3 has its own saved-status word. The saved-status write strobe updates only the current mode's word, and the saved-status output shows only the current mode's word.
- R9: In user, system or any unlisted mode, the saved-status output reads zero and the saved-status write strobe changes no saved-status word.
- R10: A saved-status write in an exception mode is shown on the saved-status output one edge later, in place of the old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current operating mode encoding |
| rd_a_idx | input | 4 | Logical register number for read port A |
| rd_a_data | output | DATA_W | Registered read data, port A |
| rd_b_idx | input | 4 | Logical register number for read port B |
| rd_b_data | output | DATA_W | Registered read data, port B |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | DATA_W | Register write data |
| sav_wr_en | input | 1 | Saved-status write strobe for the current mode |
| sav_wr_data | input | STAT_W | Saved-status write data |
| sav_rd_data | output | STAT_W | Registered saved-status word of the current mode |

## Verification
A directed phase first fills the user copies of every register. It then writes the same logical numbers in fast-interrupt mode and in each of the four two-register exception modes, and returns to user mode. The read-back at that point separates correct banking from aliasing between banks and from a missing private copy. A long random phase follows, with an illegal mode value mixed into the seven legal ones. Read indices are often forced equal to the write index, so that same-cycle write-through is checked separately from ordinary stored reads. Saved-status writes issued in user and system modes are followed by reads in every exception mode, which shows any write that should have been ignored but reached a bank.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpu_mode_e;

  // Bank identifiers; the order of the four small banks sets their physical layout.
  typedef enum logic [2:0] {
    BANK_NONE = 3'd0,
    BANK_FIQ  = 3'd1,
    BANK_IRQ  = 3'd2,
    BANK_SVC  = 3'd3,
    BANK_ABT  = 3'd4,
    BANK_UND  = 3'd5
  } bank_e;

  localparam int LOG_REGS     = 16;
  localparam int LOG_IDX_W    = $clog2(LOG_REGS);
  localparam int PC_IDX       = LOG_REGS - 1;
  localparam int FIQ_FIRST    = 8;
  localparam int PRIV_FIRST   = 13;
  localparam int FIQ_BANKED   = PC_IDX - FIQ_FIRST;
  localparam int PRIV_BANKED  = PC_IDX - PRIV_FIRST;
  localparam int NUM_PRIV     = 4;
  localparam int FIQ_BASE     = LOG_REGS;
  localparam int PRIV_BASE    = FIQ_BASE + FIQ_BANKED;
  localparam int PHYS_REGS    = PRIV_BASE + NUM_PRIV * PRIV_BANKED;
  localparam int PHYS_IDX_W   = $clog2(PHYS_REGS);
  localparam int NUM_STAT     = 1 + NUM_PRIV;

  function automatic bank_e mode_to_bank(logic [4:0] m);
    bank_e b;
    case (m)
      MODE_FIQ: b = BANK_FIQ;
      MODE_IRQ: b = BANK_IRQ;
      MODE_SVC: b = BANK_SVC;
      MODE_ABT: b = BANK_ABT;
      MODE_UND: b = BANK_UND;
      default:  b = BANK_NONE;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import bankrf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [4:0]          mode,
  output bank_e               bank,
  output logic [NUM_STAT-1:0] stat_sel
);

  always_comb begin
    bank     = mode_to_bank(mode);
    stat_sel = '0;
    if (bank != BANK_NONE) stat_sel[int'(bank) - 1] = 1'b1;
  end

  AST_STAT_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stat_sel)); // R8

  AST_SYS_NO_BANK: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SYS || mode == MODE_USR) |-> (stat_sel == '0)); // R9

endmodule

// File: rtl/phys_map.sv
module phys_map
  import bankrf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  bank_e                 bank,
  input  logic [LOG_IDX_W-1:0]  idx,
  output logic [PHYS_IDX_W-1:0] phys
);

  int li;
  int loc;

  always_comb begin
    li  = int'(idx);
    loc = li;
    if (li != PC_IDX) begin
      if (bank == BANK_FIQ && li >= FIQ_FIRST)
        loc = FIQ_BASE + (li - FIQ_FIRST);
      else if (bank != BANK_NONE && bank != BANK_FIQ && li >= PRIV_FIRST)
        loc = PRIV_BASE + (int'(bank) - int'(BANK_IRQ)) * PRIV_BANKED + (li - PRIV_FIRST);
    end
    phys = PHYS_IDX_W'(loc);
  end

  AST_LOW_SHARED: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) < FIQ_FIRST) |-> (int'(phys) == int'(idx))); // R1

  AST_PC_SHARED: assert property (@(posedge clk) disable iff (rst)
    (int'(idx) == PC_IDX) |-> (int'(phys) == PC_IDX)); // R4

  AST_USER_VIEW: assert property (@(posedge clk) disable iff (rst)
    (bank == BANK_NONE) |-> (int'(phys) == int'(idx))); // R5

  AST_PHYS_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(phys) < PHYS_REGS); // R2

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)
        rdata[g] <= '0;
      else if (we && waddr == raddr[g])
        rdata[g] <= wdata;
      else
        rdata[g] <= mem[raddr[g]];
    end

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (we && waddr == raddr[g]) |=> (rdata[g] == $past(wdata))); // R7
  end

endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int STAT_W = 32,
  parameter int NUM    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM-1:0]    sel,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data
);

  logic [STAT_W-1:0] words [NUM];
  logic [STAT_W-1:0] cur;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (rst)
        words[i] <= '0;
      else if (wr_en && sel[i])
        words[i] <= wr_data;
    end
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM; i++)
      if (sel[i]) cur = cur | words[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (wr_en && (|sel))
      rd_data <= wr_data;
    else
      rd_data <= cur;
  end

  AST_NO_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(|sel) |=> (rd_data == '0)); // R9

  AST_STAT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (|sel)) |=> (rd_data == $past(wr_data))); // R10

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((|sel) && !wr_en && $stable(sel)) |=> (rd_data == $past(cur))); // R8

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4:0]           mode,
  input  logic [LOG_IDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [LOG_IDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [LOG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 sav_wr_en,
  input  logic [STAT_W-1:0]    sav_wr_data,
  output logic [STAT_W-1:0]    sav_rd_data
);

  localparam int NPORT = 3;  // two reads, one write
  localparam int NRD   = 2;

  bank_e                                  bank;
  logic [NUM_STAT-1:0]                    stat_sel;
  logic [NPORT-1:0][LOG_IDX_W-1:0]        log_idx;
  logic [NPORT-1:0][PHYS_IDX_W-1:0]       phys_idx;
  logic [NRD-1:0][PHYS_IDX_W-1:0]         rd_phys;
  logic [NRD-1:0][DATA_W-1:0]             rd_out;

  assign log_idx[0] = rd_a_idx;
  assign log_idx[1] = rd_b_idx;
  assign log_idx[2] = wr_idx;

  bank_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .bank     (bank),
    .stat_sel (stat_sel)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    phys_map u_map (
      .clk  (clk),
      .rst  (rst),
      .bank (bank),
      .idx  (log_idx[p]),
      .phys (phys_idx[p])
    );
  end

  assign rd_phys[0] = phys_idx[0];
  assign rd_phys[1] = phys_idx[1];

  gpr_storage #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_REGS),
    .NRD    (NRD)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (phys_idx[2]),
    .wdata (wr_data),
    .raddr (rd_phys),
    .rdata (rd_out)
  );

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];

  status_bank #(
    .STAT_W (STAT_W),
    .NUM    (NUM_STAT)
  ) u_status (
    .clk     (clk),
    .rst     (rst),
    .sel     (stat_sel),
    .wr_en   (sav_wr_en),
    .wr_data (sav_wr_data),
    .rd_data (sav_rd_data)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && sav_rd_data == '0)); // R6

  AST_FIQ_PRIVATE: assert property (@(posedge clk) disable iff (rst)
    (bank == BANK_FIQ && int'(wr_idx) >= FIQ_FIRST && int'(wr_idx) < PC_IDX)
      |-> (int'(phys_idx[2]) >= FIQ_BASE)); // R2

  AST_PRIV_MID_SHARED: assert property (@(posedge clk) disable iff (rst)
    (bank != BANK_NONE && bank != BANK_FIQ && int'(wr_idx) < PRIV_FIRST)
      |-> (int'(phys_idx[2]) < FIQ_BASE)); // R3

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

  localparam int DW = 32;
  localparam int SW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [4:0]    mode;
  logic [3:0]    rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en, sav_wr_en;
  logic [SW-1:0] sav_wr_data, sav_rd_data;

  banked_regfile #(.DATA_W(DW), .STAT_W(SW)) uut (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data),
    .sav_rd_data(sav_rd_data)
  );

  // Behavioural model: storage keyed by owner name and register number.
  bit [DW-1:0] gm [string];
  bit [SW-1:0] sm [string];

  int checks = 0;
  int fails  = 0;
  bit pending = 0;
  bit done = 0;
  bit va, vb;
  logic [DW-1:0] ea, eb;
  logic [SW-1:0] es;
  string ta, tb, ts;

  logic [4:0] mlist [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111, 5'b00110};

  function automatic string mname(logic [4:0] m);
    case (m)
      5'b10001: return "fiq";
      5'b10010: return "irq";
      5'b10011: return "svc";
      5'b10111: return "abt";
      5'b11011: return "und";
      5'b11111: return "sys";
      default:  return "usr";
    endcase
  endfunction

  function automatic bit small_bank(string n);
    return (n == "irq" || n == "svc" || n == "abt" || n == "und");
  endfunction

  function automatic string gkey(logic [4:0] m, logic [3:0] i);
    string n = mname(m);
    string own = "usr";
    if (i != 4'd15) begin
      if (n == "fiq" && i >= 4'd8) own = "fiq";
      else if (small_bank(n) && i >= 4'd13) own = n;
    end
    return $sformatf("%s_%0d", own, i);
  endfunction

  function automatic string rtag(logic [4:0] m, logic [3:0] i);
    string n = mname(m);
    if (i < 4'd8) return "R1";
    if (i == 4'd15) return "R4";
    if (n == "fiq") return "R2";
    if (small_bank(n)) return "R3";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (pending) begin
      if (va) chk(ta, 64'(rd_a_data), 64'(ea), "read port A");
      if (vb) chk(tb, 64'(rd_b_data), 64'(eb), "read port B");
      chk(ts, 64'(sav_rd_data), 64'(es), "saved status");
    end
  endtask

  task automatic step(bit we, logic [3:0] wi, logic [DW-1:0] wd,
                      logic [3:0] ai, logic [3:0] bi, logic [4:0] md,
                      bit swe, logic [SW-1:0] swd);
    string ka, kb, kw, sn;
    @(negedge clk);
    compare();
    mode = md; rd_a_idx = ai; rd_b_idx = bi;
    wr_en = we; wr_idx = wi; wr_data = wd;
    sav_wr_en = swe; sav_wr_data = swd;
    ka = gkey(md, ai); kb = gkey(md, bi); kw = gkey(md, wi);
    if (we && kw == ka) begin ea = wd; va = 1; ta = "R7"; end
    else if (gm.exists(ka)) begin ea = gm[ka]; va = 1; ta = rtag(md, ai); end
    else va = 0;
    if (we && kw == kb) begin eb = wd; vb = 1; tb = "R7"; end
    else if (gm.exists(kb)) begin eb = gm[kb]; vb = 1; tb = rtag(md, bi); end
    else vb = 0;
    sn = mname(md);
    if (sn == "usr" || sn == "sys") begin es = '0; ts = "R9"; end
    else if (swe) begin es = swd; ts = "R10"; end
    else begin es = sm[sn]; ts = "R8"; end
    if (we) gm[kw] = wd;
    if (swe && sn != "usr" && sn != "sys") sm[sn] = swd;
    pending = 1;
  endtask

  task automatic rd_only(logic [3:0] ai, logic [3:0] bi, logic [4:0] md);
    step(0, 4'd0, '0, ai, bi, md, 0, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; mode = 5'b10000; rd_a_idx = 0; rd_b_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = '0; sav_wr_en = 0; sav_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", 64'(rd_a_data), 64'd0, "reset port A");
    chk("R6", 64'(rd_b_data), 64'd0, "reset port B");
    chk("R6", 64'(sav_rd_data), 64'd0, "reset saved status");
    rst = 0;
    foreach (mlist[k]) if (mname(mlist[k]) != "usr" && mname(mlist[k]) != "sys")
      sm[mname(mlist[k])] = '0;

    // R5: user copies of all registers
    for (int i = 0; i < 16; i++)
      step(1, 4'(i), 32'h1000_0000 + i, 4'(i), 4'((i + 15) % 16), 5'b10000, 0, '0);
    // R2: private fast-interrupt copies of r8..r14
    for (int i = 8; i < 15; i++)
      step(1, 4'(i), 32'h2000_0000 + i, 4'(i - 1), 4'(i), 5'b10001, 1, 32'hF1F1_0000 + i);
    // R3: each small bank writes r12..r14; r12 lands in the user copy
    for (int m = 2; m < 6; m++)
      for (int i = 12; i < 15; i++)
        step(1, 4'(i), 32'h3000_0000 + (m << 8) + i, 4'(i), 4'd8, mlist[m], 1, 32'h5A00 + m);
    // R1/R4: shared registers written from system mode and fast mode
    step(1, 4'd3, 32'hCAFE_0003, 4'd3, 4'd15, 5'b11111, 1, 32'hDEAD);  // R9 write ignored
    step(1, 4'd15, 32'hCAFE_000F, 4'd15, 4'd3, 5'b10001, 0, '0);
    // Read every register back in every mode
    foreach (mlist[k])
      for (int i = 0; i < 16; i += 2)
        rd_only(4'(i), 4'(i + 1), mlist[k]);

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      logic [3:0] wi = 4'($urandom_range(0, 15));
      logic [3:0] ai = 4'($urandom_range(0, 15));
      logic [3:0] bi = 4'($urandom_range(0, 15));
      if (n % 5 == 0) ai = wi;
      if (n % 7 == 0) bi = wi;
      step(bit'($urandom_range(0, 1)), wi, $urandom, ai, bi,
           mlist[$urandom_range(0, 7)], ($urandom_range(0, 3) == 0), $urandom);
    end
    rd_only(4'd0, 4'd1, 5'b10000);
    @(negedge clk);
    compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule